// File: doc/BRIEF.md
# Two-Way Doorbell Mailbox

This block lets a host bus master and an embedded I/O processor hand each other single 32-bit words. Each side has its own register port made of a write strobe, an address and write data, plus read data decoded from the address. Each side finds the doorbell at offset 0x0. A write there from one side latches the word for the other side and raises a pending flag. That flag drives a maskable interrupt toward the receiver. A read of the doorbell offset returns the word the other side last sent, never the reader's own outgoing word.

The receiver reads the word and then acknowledges it, and the two sides acknowledge differently. The processor writes a 1 to bit 0 of its status register at offset 0x4. The host writes any value at all to its interrupt status register at offset 0x4. Each side has a mask register at offset 0x8. Bit 0 set means the interrupt is masked. Masking hides the interrupt but keeps the pending flag.

The register ports are plain single-cycle strobes. Every access completes in the cycle it is presented, so there is no valid/ready handshake and no back-pressure. Reads are combinational from the address. A write takes effect at the next rising clock edge. One clock serves both sides.

Top module: `doorbell_mailbox`

## Requirements
- R1: After reset both stored words are 0, both pending flags are 0, both mask bits are 1, and both interrupt outputs are low.
- R2: A host write to offset 0x0 stores the word for the processor and sets the processor-bound pending flag. The processor then reads that word at its offset 0x0.
- R3: A host read at offset 0x0 returns the word the processor last wrote, not the word the host itself sent.
- R4: A processor write to offset 0x0 stores the word for the host and sets the host-bound pending flag. The host then reads that word at its offset 0x0.
- R5: Each interrupt output is high exactly when its pending flag is 1 and its mask bit is 0. The mask bit is bit 0 of offset 0x8 on that side, and 1 means masked. Changing the mask does not change the pending flag, so unmasking a pending flag raises the interrupt in the cycle after the mask write.
- R6: A processor write at offset 0x4 with bit 0 = 1 clears the processor-bound pending flag. With bit 0 = 0 the write has no effect. Neither write changes the stored word.
- R7: A host write of any value at offset 0x4, including 0, clears the host-bound pending flag and leaves the stored word unchanged.
- R8: If a doorbell write and a clear for the same direction land in the same cycle, the pending flag ends up set.
- R9: A second doorbell write in the same direction before the clear replaces the stored word, and the pending flag stays set.
- R10: On each side, a read at offset 0x4 returns that side's incoming pending flag in bit 0 and a read at 0x8 returns its mask in bit 0. All other bits of these reads, and every read of an unmapped offset, are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| host_irq | output | 1 | Interrupt to the host |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_addr | input | 4 | Processor register offset |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data for cpu_addr |
| cpu_irq | output | 1 | Interrupt to the processor |

## Verification
The assertions assume each strobe stays high for exactly one clock per access and that address and data are steady around the sampling edge. The stimulus changes inputs only on falling edges and holds each strobe for a single cycle. The assertions also assume no write occurs while reset is active, and the stimulus only starts accesses after reset has been released. The collision cases are produced on purpose by driving both ports in the same cycle, so the set-versus-clear rule is checked directly.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFF_BELL = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_MASK = 4'h8;
endpackage

// File: rtl/doorbell_channel.sv
module doorbell_channel
  import doorbell_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             ack,
  input  logic             mask_wr,
  input  logic             mask_val,
  output logic [WIDTH-1:0] word,
  output logic             pending,
  output logic             mask,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word    <= '0;
      pending <= 1'b0;
      mask    <= 1'b1;
    end else begin
      if (load) word <= load_data;
      if (load)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
      if (mask_wr) mask <= mask_val;
    end
  end

  assign irq = pending & ~mask;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pending);
  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !load) |=> !pending);
  // R9
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending);
  // R7
  word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word));
  // R5
  mask_keeps_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !ack && !load) |=> $stable(pending));
endmodule

// File: rtl/doorbell_port.sv
module doorbell_port
  import doorbell_pkg::*;
#(
  parameter int WIDTH     = DATA_W,
  parameter int AW        = ADDR_W,
  parameter bit CLEAR_ANY = 1'b0
) (
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] peer_word,
  input  logic             in_pending,
  input  logic             in_mask,
  output logic             bell_wr,
  output logic             stat_ack,
  output logic             mask_wr,
  output logic [WIDTH-1:0] rdata
);
  localparam int PAD = WIDTH - 1;

  assign bell_wr = wr && (addr == OFF_BELL);
  assign mask_wr = wr && (addr == OFF_MASK);

  generate
    if (CLEAR_ANY) begin : g_any
      assign stat_ack = wr && (addr == OFF_STAT);
    end else begin : g_bit
      assign stat_ack = wr && (addr == OFF_STAT) && wdata[0];
    end
  endgenerate

  always_comb begin
    unique case (addr)
      OFF_BELL: rdata = peer_word;
      OFF_STAT: rdata = {{PAD{1'b0}}, in_pending};
      OFF_MASK: rdata = {{PAD{1'b0}}, in_mask};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox
  import doorbell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_irq,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_irq
);
  logic              h_bell, h_ack, h_mwr, c_bell, c_ack, c_mwr;
  logic [DATA_W-1:0] to_cpu_word, to_host_word;
  logic              to_cpu_pend, to_host_pend, to_cpu_mask, to_host_mask;
  logic              unused_wdata;

  assign unused_wdata = ^{host_wdata[DATA_W-1:1], cpu_wdata[DATA_W-1:1]};

  doorbell_port #(.CLEAR_ANY(1'b1)) u_host_port (
    .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
    .peer_word(to_host_word), .in_pending(to_host_pend), .in_mask(to_host_mask),
    .bell_wr(h_bell), .stat_ack(h_ack), .mask_wr(h_mwr), .rdata(host_rdata));

  doorbell_port #(.CLEAR_ANY(1'b0)) u_cpu_port (
    .wr(cpu_wr), .addr(cpu_addr), .wdata(cpu_wdata),
    .peer_word(to_cpu_word), .in_pending(to_cpu_pend), .in_mask(to_cpu_mask),
    .bell_wr(c_bell), .stat_ack(c_ack), .mask_wr(c_mwr), .rdata(cpu_rdata));

  doorbell_channel u_to_cpu (
    .clk(clk), .rst_n(rst_n), .load(h_bell), .load_data(host_wdata),
    .ack(c_ack), .mask_wr(c_mwr), .mask_val(cpu_wdata[0]),
    .word(to_cpu_word), .pending(to_cpu_pend), .mask(to_cpu_mask), .irq(cpu_irq));

  doorbell_channel u_to_host (
    .clk(clk), .rst_n(rst_n), .load(c_bell), .load_data(cpu_wdata),
    .ack(h_ack), .mask_wr(h_mwr), .mask_val(host_wdata[0]),
    .word(to_host_word), .pending(to_host_pend), .mask(to_host_mask), .irq(host_irq));

  // R2
  host_bell_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFF_BELL && !cpu_mask_next()) |=> cpu_irq);
  // R4
  cpu_bell_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == OFF_BELL) |=> (host_rdata == $past(cpu_wdata) || host_addr != OFF_BELL));

  function automatic logic cpu_mask_next();
    return (cpu_wr && cpu_addr == OFF_MASK) ? cpu_wdata[0] : to_cpu_mask;
  endfunction
endmodule

// File: tb/doorbell_mailbox_tb.sv
module doorbell_mailbox_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, cpu_wr = 1'b0;
  logic [3:0]  host_addr = '0, cpu_addr = '0;
  logic [31:0] host_wdata = '0, cpu_wdata = '0;
  logic [31:0] host_rdata, cpu_rdata;
  logic        host_irq, cpu_irq;
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  doorbell_mailbox u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_irq(host_irq),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_irq(cpu_irq));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic cpu_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic both_write(input logic [3:0] ha, input logic [31:0] hd,
                            input logic [3:0] ca, input logic [31:0] cd);
    @(negedge clk);
    host_wr = 1'b1; host_addr = ha; host_wdata = hd;
    cpu_wr  = 1'b1; cpu_addr  = ca; cpu_wdata  = cd;
    @(negedge clk); host_wr = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic look(input logic [3:0] ha, input logic [3:0] ca);
    host_addr = ha; cpu_addr = ca; #1;
  endtask

  task automatic t_reset;
    look(4'h0, 4'h0);
    check("R1", "host word", host_rdata, 32'h0);
    check("R1", "cpu word", cpu_rdata, 32'h0);
    look(4'h4, 4'h4);
    check("R1", "host pend", host_rdata, 32'h0);
    check("R1", "cpu pend", cpu_rdata, 32'h0);
    look(4'h8, 4'h8);
    check("R1", "host mask", host_rdata, 32'h1);
    check("R1", "cpu mask", cpu_rdata, 32'h1);
    check("R1", "irqs", {30'h0, host_irq, cpu_irq}, 32'h0);
    look(4'hC, 4'hC);
    check("R10", "unmapped", host_rdata | cpu_rdata, 32'h0);
  endtask

  task automatic t_host_to_cpu;
    cpu_write(4'h8, 32'h0);
    host_write(4'h0, 32'hA5A5_0001);
    look(4'h0, 4'h0);
    check("R2", "cpu reads word", cpu_rdata, 32'hA5A5_0001);
    check("R3", "host no echo", host_rdata, 32'h0);
    check("R2", "cpu_irq", {31'h0, cpu_irq}, 32'h1);
    look(4'h4, 4'h4);
    check("R10", "cpu stat", cpu_rdata, 32'h1);
  endtask

  task automatic t_cpu_clear;
    cpu_write(4'h4, 32'hFFFF_FFFE);
    look(4'h0, 4'h4);
    check("R6", "bit0=0 ignored", cpu_rdata, 32'h1);
    cpu_write(4'h4, 32'h1);
    look(4'h0, 4'h4);
    check("R6", "cleared", cpu_rdata, 32'h0);
    check("R6", "irq low", {31'h0, cpu_irq}, 32'h0);
    look(4'h0, 4'h0);
    check("R6", "word kept", cpu_rdata, 32'hA5A5_0001);
  endtask

  task automatic t_cpu_to_host;
    host_write(4'h8, 32'h0);
    cpu_write(4'h0, 32'hDEAD_BEEF);
    look(4'h0, 4'h0);
    check("R4", "host reads word", host_rdata, 32'hDEAD_BEEF);
    check("R4", "host_irq", {31'h0, host_irq}, 32'h1);
    check("R3", "cpu sees host word", cpu_rdata, 32'hA5A5_0001);
    look(4'h4, 4'h0);
    check("R10", "host stat", host_rdata, 32'h1);
  endtask

  task automatic t_host_clear;
    host_write(4'h4, 32'h0);
    look(4'h4, 4'h0);
    check("R7", "cleared by zero", host_rdata, 32'h0);
    check("R7", "irq low", {31'h0, host_irq}, 32'h0);
    look(4'h0, 4'h0);
    check("R7", "word kept", host_rdata, 32'hDEAD_BEEF);
  endtask

  task automatic t_mask;
    host_write(4'h8, 32'h1);
    cpu_write(4'h0, 32'h1234_5678);
    look(4'h4, 4'h0);
    check("R5", "pending while masked", host_rdata, 32'h1);
    check("R5", "irq masked", {31'h0, host_irq}, 32'h0);
    host_write(4'h8, 32'h0);
    look(4'h4, 4'h0);
    check("R5", "irq on unmask", {31'h0, host_irq}, 32'h1);
    host_write(4'h4, 32'h5);
    look(4'h4, 4'h0);
    check("R7", "clear nonzero", host_rdata, 32'h0);
  endtask

  task automatic t_overwrite;
    host_write(4'h0, 32'h1111_1111);
    host_write(4'h0, 32'h2222_2222);
    look(4'h0, 4'h0);
    check("R9", "latest word", cpu_rdata, 32'h2222_2222);
    look(4'h0, 4'h4);
    check("R9", "still pending", cpu_rdata, 32'h1);
  endtask

  task automatic t_set_wins;
    both_write(4'h0, 32'h3333_3333, 4'h4, 32'h1);
    look(4'h0, 4'h4);
    check("R8", "cpu side set wins", cpu_rdata, 32'h1);
    both_write(4'h4, 32'h0, 4'h0, 32'h4444_4444);
    look(4'h4, 4'h0);
    check("R8", "host side set wins", host_rdata, 32'h1);
    look(4'h0, 4'h0);
    check("R8", "host word", host_rdata, 32'h4444_4444);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_host_to_cpu();
    t_cpu_clear();
    t_cpu_to_host();
    t_host_clear();
    t_mask();
    t_overwrite();
    t_set_wins();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule